// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a byte-wide parallel flash device. It runs one program or erase request from start to finish. A start pulse carries the operation type, the target address and the data byte. The block then drives the fixed unlock-and-command write sequence onto the bus. After that it reads the target address again and again until the device reports that the operation is complete. It makes one last read of the target address and reports that byte as the verified data, or it gives up after a set number of polls.

Completion is judged only from what the device returns on the data bus. No ready pin is used. Two methods are available, chosen at start:
- **Bit-7 method:** bit 7 of each status read is compared with the value expected at completion. For a program this is bit 7 of the data byte. For an erase it is 1.
- **Toggle method:** bit 6 must read the same on two successive reads.

Each bus access takes one clock cycle. Every write strobe is followed by one cycle with chip select released. During polling, chip select stays asserted, and each read strobe is followed by one cycle in which the read strobe is low and the completion decision is taken.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, bus_cs_o, bus_we_o, bus_oe_o, busy_o, done_o and timeout_o are all 0.
- R2: start_i is taken only when busy_o is 0. A start pulse while busy is ignored: the bus sequence and the result of the running operation are unchanged.
- R3: A program (op_erase_i=0) issues exactly 4 one-cycle write strobes, each with bus_cs_o=1 and each followed by a cycle with bus_cs_o=0. The (address, data) pairs, in order, are: (UNLK_A,0xAA), (UNLK_B,0x55), (UNLK_A,0xA0), (target,data).
- R4: An erase (op_erase_i=1) issues exactly 6 such writes, in this order: (UNLK_A,0xAA), (UNLK_B,0x55), (UNLK_A,0x80), (UNLK_A,0xAA), (UNLK_B,0x55), (target,0x30).
- R5: Polling reads of the target address start only after the last write of the sequence. bus_cs_o stays 1 from the first poll read until the final read has ended.
- R6: In bit-7 mode (mode_toggle_i=0), a program is complete on the first poll read whose bit 7 equals bit 7 of the data byte.
- R7: In bit-7 mode, an erase is complete on the first poll read whose bit 7 is 1.
- R8: In toggle mode (mode_toggle_i=1), the operation is complete on the first poll read whose bit 6 equals bit 6 of the read just before it. The first poll read never completes.
- R9: Once completion is detected, exactly one more read of the target is made. Its byte appears on verify_o and is held until the next final read.
- R10: If MAX_POLLS poll reads pass without completion, done_o pulses with timeout_o=1, no final read is made, and verify_o keeps its old value. A completion seen on read number MAX_POLLS still counts as success.
- R11: done_o is high for exactly one cycle at the end of each operation, and busy_o is 0 in the following cycle.
- R12: bus_we_o and bus_oe_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle-bit method, 0 = bit-7 method |
| addr_i | input | AW | Target address |
| data_i | input | 8 | Byte to program |
| bus_addr_o | output | AW | Flash bus address |
| bus_wdata_o | output | 8 | Flash bus write data |
| bus_rdata_i | input | 8 | Flash bus read data |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_we_o | output | 1 | Write strobe |
| bus_oe_o | output | 1 | Read strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| timeout_o | output | 1 | High with done_o when the poll limit was hit |
| verify_o | output | 8 | Byte returned by the final read |

## Verification
The bench builds the block with MAX_POLLS=8. At that value a busy period of 7 reads completes on the last allowed poll, and a busy period of 8 reads times out, so both sides of the limit are exercised within a few dozen cycles. The flash model's busy length and data bytes are chosen so that, in toggle mode, the first data read differs in bit 6 from the last toggling status read. This puts the exact number of poll reads, including the two-read minimum, under check.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSTB, ST_WGAP, ST_PRD, ST_PCHK, ST_FRD, ST_FIN
  } fpc_state_t;

  localparam logic [7:0] CMD_UNLK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLK2 = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_SECT  = 8'h30;
endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table #(
  parameter int AW = 16,
  parameter logic [AW-1:0] UNLK_A = 'h555,
  parameter logic [AW-1:0] UNLK_B = 'h2AA
) (
  input  logic          op_erase_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [7:0]    tgt_data_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          last_o
);
  import fpc_pkg::*;

  always_comb begin
    wr_addr_o = UNLK_A;
    wr_data_o = CMD_UNLK1;
    if (!op_erase_i) begin
      last_o = (idx_i == 3'd3);
      unique case (idx_i)
        3'd0: begin wr_addr_o = UNLK_A; wr_data_o = CMD_UNLK1; end
        3'd1: begin wr_addr_o = UNLK_B; wr_data_o = CMD_UNLK2; end
        3'd2: begin wr_addr_o = UNLK_A; wr_data_o = CMD_PROG;  end
        default: begin wr_addr_o = tgt_addr_i; wr_data_o = tgt_data_i; end
      endcase
    end else begin
      last_o = (idx_i == 3'd5);
      unique case (idx_i)
        3'd0, 3'd3: begin wr_addr_o = UNLK_A; wr_data_o = CMD_UNLK1; end
        3'd1, 3'd4: begin wr_addr_o = UNLK_B; wr_data_o = CMD_UNLK2; end
        3'd2:       begin wr_addr_o = UNLK_A; wr_data_o = CMD_ERASE; end
        default:    begin wr_addr_o = tgt_addr_i; wr_data_o = CMD_SECT; end
      endcase
    end
  end
endmodule

// File: rtl/fpc_judge.sv
module fpc_judge (
  input  logic mode_toggle_i,
  input  logic op_erase_i,
  input  logic exp_b7_i,
  input  logic cur_b7_i,
  input  logic cur_b6_i,
  input  logic prev_b6_i,
  input  logic two_reads_i,
  output logic complete_o
);
  logic b7_target;

  always_comb begin
    b7_target = op_erase_i ? 1'b1 : exp_b7_i;
    if (mode_toggle_i) complete_o = two_reads_i && (cur_b6_i == prev_b6_i);
    else               complete_o = (cur_b7_i == b7_target);
  end
endmodule

// File: rtl/fpc_poll_cnt.sv
module fpc_poll_cnt #(
  parameter int MAX_POLLS = 4096,
  localparam int CW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic two_o,
  output logic at_lim_o
);
  localparam logic [CW-1:0] LIM = CW'(MAX_POLLS);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign two_o    = (cnt_q >= CW'(2));
  assign at_lim_o = (cnt_q == LIM);

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q <= LIM);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int AW = 16,
  parameter int MAX_POLLS = 4096,
  parameter logic [AW-1:0] UNLK_A = 'h555,
  parameter logic [AW-1:0] UNLK_B = 'h2AA
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          mode_toggle_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  output logic          bus_cs_o,
  output logic          bus_we_o,
  output logic          bus_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic [7:0]    verify_o
);
  import fpc_pkg::*;

  fpc_state_t    st_q;
  logic          erase_q, tog_q, to_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q, verify_q;
  logic [2:0]    idx_q;
  logic          rd_b7_q, rd_b6_q, prv_b6_q;
  logic [AW-1:0] seq_addr;
  logic [7:0]    seq_data;
  logic          seq_last, complete, two_reads, at_lim;

  fpc_cmd_table #(.AW(AW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)) u_tbl (
    .op_erase_i (erase_q),
    .idx_i      (idx_q),
    .tgt_addr_i (addr_q),
    .tgt_data_i (data_q),
    .wr_addr_o  (seq_addr),
    .wr_data_o  (seq_data),
    .last_o     (seq_last)
  );

  fpc_judge u_judge (
    .mode_toggle_i (tog_q),
    .op_erase_i    (erase_q),
    .exp_b7_i      (data_q[7]),
    .cur_b7_i      (rd_b7_q),
    .cur_b6_i      (rd_b6_q),
    .prev_b6_i     (prv_b6_q),
    .two_reads_i   (two_reads),
    .complete_o    (complete)
  );

  fpc_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q == ST_WGAP),
    .inc_i    (st_q == ST_PRD),
    .two_o    (two_reads),
    .at_lim_o (at_lim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      erase_q  <= 1'b0;
      tog_q    <= 1'b0;
      to_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      verify_q <= '0;
      idx_q    <= '0;
      rd_b7_q  <= 1'b0;
      rd_b6_q  <= 1'b0;
      prv_b6_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          erase_q <= op_erase_i;
          tog_q   <= mode_toggle_i;
          addr_q  <= addr_i;
          data_q  <= data_i;
          idx_q   <= '0;
          to_q    <= 1'b0;
          st_q    <= ST_WSTB;
        end
        ST_WSTB: st_q <= ST_WGAP;
        ST_WGAP: begin
          if (seq_last) st_q <= ST_PRD;
          else begin
            idx_q <= idx_q + 3'd1;
            st_q  <= ST_WSTB;
          end
        end
        ST_PRD: begin
          rd_b7_q  <= bus_rdata_i[7];
          rd_b6_q  <= bus_rdata_i[6];
          prv_b6_q <= rd_b6_q;
          st_q     <= ST_PCHK;
        end
        ST_PCHK: begin
          if (complete) st_q <= ST_FRD;
          else if (at_lim) begin
            to_q <= 1'b1;
            st_q <= ST_FIN;
          end else st_q <= ST_PRD;
        end
        ST_FRD: begin
          verify_q <= bus_rdata_i;
          st_q     <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    bus_we_o    = 1'b0;
    bus_oe_o    = 1'b0;
    bus_cs_o    = 1'b0;
    unique case (st_q)
      ST_WSTB: begin
        bus_cs_o    = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = seq_addr;
        bus_wdata_o = seq_data;
      end
      ST_PRD, ST_FRD: begin
        bus_cs_o   = 1'b1;
        bus_oe_o   = 1'b1;
        bus_addr_o = addr_q;
      end
      ST_PCHK: begin
        bus_cs_o   = 1'b1;
        bus_addr_o = addr_q;
      end
      default: ;
    endcase
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FIN);
  assign timeout_o = (st_q == ST_FIN) && to_q;
  assign verify_o  = verify_q;

  // R12
  rw_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_oe_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R10
  to_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  // R5
  cs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |=> (bus_cs_o || done_o));
  // R9
  final_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> $past(bus_oe_o));
  // R2
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: tb/flash_poll_ctrl_bench.sv
module flash_poll_ctrl_bench;
  localparam int AW = 16;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, mode_tog = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [AW-1:0] b_addr;
  logic [7:0] b_wdata, b_rdata, verify;
  logic b_cs, b_we, b_oe, busy, done, tmo;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_poll_ctrl #(.AW(AW), .MAX_POLLS(MAXP)) u_flash_poll_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_erase_i(op_erase),
    .mode_toggle_i(mode_tog), .addr_i(addr), .data_i(data),
    .bus_addr_o(b_addr), .bus_wdata_o(b_wdata), .bus_rdata_i(b_rdata),
    .bus_cs_o(b_cs), .bus_we_o(b_we), .bus_oe_o(b_oe), .busy_o(busy),
    .done_o(done), .timeout_o(tmo), .verify_o(verify)
  );

  // flash device model
  logic m_erase = 1'b0;
  logic [7:0] m_mem = '0;
  logic [AW-1:0] m_tgt = '0;
  int m_busy = 0;
  int busy_left = 0;
  logic tog = 1'b0;
  int wr_n = 0, rd_n = 0, wr_bad = 0, cs_brk = 0, clash = 0, early_rd = 0;
  logic polling = 1'b0;

  assign b_rdata = (busy_left != 0) ? {(m_erase ? 1'b0 : ~m_mem[7]), tog, 6'h00} : m_mem;

  function automatic logic [AW+7:0] exp_wr(input logic er, input int k,
                                           input logic [AW-1:0] a, input logic [7:0] d);
    logic [AW-1:0] ua = 16'h0555, ub = 16'h02AA;
    if (!er) begin
      case (k)
        0: return {ua, 8'hAA};
        1: return {ub, 8'h55};
        2: return {ua, 8'hA0};
        default: return {a, d};
      endcase
    end else begin
      case (k)
        0, 3: return {ua, 8'hAA};
        1, 4: return {ub, 8'h55};
        2: return {ua, 8'h80};
        default: return {a, 8'h30};
      endcase
    end
  endfunction

  always @(posedge clk) begin
    if (b_we && b_oe) clash++;
    if (b_cs && b_we) begin
      if ({b_addr, b_wdata} != exp_wr(m_erase, wr_n, m_tgt, m_mem)) wr_bad++;
      wr_n++;
      if (wr_n == (m_erase ? 6 : 4)) busy_left <= m_busy;
    end
    if (b_cs && b_oe) begin
      if (wr_n < (m_erase ? 6 : 4) || b_addr != m_tgt) early_rd++;
      rd_n++;
      polling = 1'b1;
      if (busy_left != 0) begin
        busy_left <= busy_left - 1;
        tog <= ~tog;
      end
    end
    if (polling && !b_cs && !done) cs_brk++;
    if (done) polling = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({b_cs, b_we, b_oe, busy, done, tmo} == 6'b0, "R1 in reset", int'({b_cs, b_we, b_oe, busy, done, tmo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({b_cs, b_we, b_oe, busy, done, tmo} == 6'b0, "R1 after reset", int'({b_cs, b_we, b_oe, busy, done, tmo}), 0);
  endtask

  task automatic run_op(input logic er, input logic tg, input logic [AW-1:0] a,
                        input logic [7:0] d, input int b, input int exp_reads,
                        input logic exp_to, input bit inj, input string tag);
    logic [7:0] prev_v;
    int cyc;
    bit got;
    m_erase = er; m_mem = er ? 8'hFF : d; m_tgt = a; m_busy = b;
    tog = 1'b0; wr_n = 0; rd_n = 0; wr_bad = 0; cs_brk = 0; clash = 0; early_rd = 0;
    prev_v = verify;
    op_erase = er; mode_tog = tg; addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (cyc = 0; cyc < 500; cyc++) begin
      @(negedge clk);
      if (inj && cyc == 3) begin start = 1'b1; op_erase = ~er; data = ~d; addr = ~a; end
      else start = 1'b0;
      if (done) begin got = 1'b1; break; end
    end
    start = 1'b0;
    chk(got, {tag, " R11 done seen"}, int'(got), 1);
    chk(tmo == exp_to, {tag, " R10 timeout flag"}, int'(tmo), int'(exp_to));
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 one-cycle done"}, int'({done, busy}), 0);
    chk(wr_n == (er ? 6 : 4), {tag, er ? " R4 write count" : " R3 write count"}, wr_n, er ? 6 : 4);
    chk(wr_bad == 0, {tag, er ? " R4 write pairs" : " R3 write pairs"}, wr_bad, 0);
    chk(rd_n == exp_reads, {tag, tg ? " R8 read count" : (er ? " R7 read count" : " R6 read count")}, rd_n, exp_reads);
    chk(cs_brk == 0 && early_rd == 0, {tag, " R5 cs held, reads after writes"}, cs_brk + early_rd, 0);
    chk(clash == 0, {tag, " R12 strobe clash"}, clash, 0);
    if (exp_to) chk(verify == prev_v, {tag, " R10 verify kept"}, int'(verify), int'(prev_v));
    else        chk(verify == m_mem, {tag, " R9 verify byte"}, int'(verify), int'(m_mem));
    if (inj) chk(wr_n == 4 && wr_bad == 0, {tag, " R2 start ignored"}, wr_n, 4);
  endtask

  initial begin
    fork
      begin
        t_reset();
        run_op(1'b0, 1'b0, 16'h1234, 8'hA5, 5, 7, 1'b0, 1'b1, "prog_b7");
        run_op(1'b1, 1'b0, 16'h4000, 8'h00, 2, 4, 1'b0, 1'b0, "erase_b7");
        run_op(1'b0, 1'b1, 16'h0042, 8'h3C, 4, 7, 1'b0, 1'b0, "prog_tog");
        run_op(1'b1, 1'b1, 16'h8000, 8'h00, 3, 6, 1'b0, 1'b0, "erase_tog");
        run_op(1'b0, 1'b1, 16'h0777, 8'h5A, 0, 3, 1'b0, 1'b0, "tog_min");
        run_op(1'b0, 1'b0, 16'h0100, 8'h81, 7, 9, 1'b0, 1'b0, "lim_edge");
        run_op(1'b0, 1'b0, 16'h0200, 8'h7E, 8, 8, 1'b1, 1'b0, "lim_over");
      end
      begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule